// File: doc/BRIEF.md
# Six-button gamepad port multiplexer

This block is one controller data port as the main processor sees it. A write to the port sets a select line from bit 6 of the written byte. A read returns a byte built from a 12-bit button input. Which buttons appear in that byte depends on the select level and on a hidden phase count. The count goes up by one for each high-to-low step of the select line. This lets old three-button software and newer six-button software share the same port. The extra buttons only appear after a fast burst of select pulses.

An idle timer clears the phase count when no write arrives for a set number of cycles, so each burst starts from phase zero. Reads are registered: a read strobe returns its byte one cycle later with a valid flag. The returned byte then holds until the next read.

Button input bit positions: 0 up, 1 down, 2 left, 3 right, 4 B, 5 C, 6 A, 7 Start, 8 Z, 9 Y, 10 X, 11 Mode. The levels pass through unchanged.

Top module: `pad6_port`

## Requirements
- R1: After reset the select line is high, the phase count is zero, `rd_valid` is 0 and `rd_data` is 0x00. Each write sets the select line to `wr_data[6]`.
- R2: The phase count goes up by one only on a write with bit 6 clear while the select line is high. Writes with bit 6 set, and writes with bit 6 clear while the select line is already low, leave the count as it was. The other data bits never matter.
- R3: In a normal phase with the select line high, the read byte is {0, 1, C, B, right, left, down, up}.
- R4: In a normal phase with the select line low, the read byte is {0, 0, Start, A, 0, 0, down, up}.
- R5: In phase 3 with the select line low, the read byte is {0, 0, Start, A, 0, 0, 0, 0}.
- R6: In phase 3 with the select line high, the read byte is {0, 1, C, B, Mode, X, Y, Z}.
- R7: In phase 4 with the select line low, the read byte is {0, 0, Start, A, 1, 1, 1, 1}. In phase 4 with the select line high, the R3 format applies.
- R8: After TIMEOUT_CYCLES cycles in a row with no write, the phase count returns to zero. Any write restarts that idle count.
- R9: The phase count stops at 2^PHASE_W-1 and does not wrap. Every phase other than 3 and 4 uses the normal formats.
- R10: A read strobe gives `rd_valid` high on the next cycle, with the byte for the state at the strobe. Bit 7 of every read byte is zero. `rd_data` holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Data-port write strobe |
| wr_data | input | 8 | Written byte; bit 6 sets the select line |
| rd_en | input | 1 | Data-port read strobe |
| buttons | input | 12 | Button levels (bit map in the description) |
| rd_valid | output | 1 | Read byte valid, one cycle after `rd_en` |
| rd_data | output | 8 | Registered read byte |

## Verification
The assertions assume a read and a write never fall in the same cycle. If they did, the read would see the state from before the write, and the bench's model would not account for that. The assertions also assume the buttons stay steady from a read strobe until its result arrives. The stimulus keeps to both rules: every strobe is a single cycle driven on the falling edge, and button changes happen only between completed reads. Idle waits are kept at least ten cycles away from the timeout limit, so that read cycles in between cannot move the expiry point to the other side of a check.

// File: rtl/pad6_pkg.sv
package pad6_pkg;
  // Button vector bit positions
  localparam int BTN_W     = 12;
  localparam int B_UP      = 0;
  localparam int B_DOWN    = 1;
  localparam int B_LEFT    = 2;
  localparam int B_RIGHT   = 3;
  localparam int B_B       = 4;
  localparam int B_C       = 5;
  localparam int B_A       = 6;
  localparam int B_START   = 7;
  localparam int B_Z       = 8;
  localparam int B_Y       = 9;
  localparam int B_X       = 10;
  localparam int B_MODE    = 11;

  // Select line position in the written byte
  localparam int SEL_BIT   = 6;

  // Phases that carry special read patterns
  localparam int EXTRA_PHASE = 3;
  localparam int ONES_PHASE  = 4;

  typedef enum logic [1:0] {
    FMT_NORMAL = 2'd0,
    FMT_EXTRA  = 2'd1,
    FMT_ONES   = 2'd2
  } rd_fmt_e;
endpackage

// File: rtl/pad6_phase_ctrl.sv
module pad6_phase_ctrl
  import pad6_pkg::*;
#(
  parameter int PHASE_W        = 3,
  parameter int TIMEOUT_CYCLES = 1500
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               sel_in,
  output logic               th,
  output logic [PHASE_W-1:0] phase
);
  localparam int IDLE_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [PHASE_W-1:0] PHASE_MAX = {PHASE_W{1'b1}};
  localparam logic [IDLE_W-1:0]  IDLE_LIM  = IDLE_W'(TIMEOUT_CYCLES);
  localparam logic [IDLE_W-1:0]  IDLE_LAST = IDLE_W'(TIMEOUT_CYCLES - 1);

  logic [IDLE_W-1:0] idle_q;
  logic              fall_w;

  assign fall_w = th & ~sel_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      th     <= 1'b1;
      phase  <= '0;
      idle_q <= '0;
    end else if (wr_en) begin
      th     <= sel_in;
      idle_q <= '0;
      if (fall_w && (phase != PHASE_MAX))
        phase <= phase + 1'b1;
    end else begin
      if (idle_q != IDLE_LIM)
        idle_q <= idle_q + 1'b1;
      if (idle_q == IDLE_LAST)
        phase <= '0;
    end
  end
endmodule

// File: rtl/pad6_read_fmt.sv
module pad6_read_fmt
  import pad6_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic               th,
  input  logic [PHASE_W-1:0] phase,
  input  logic [BTN_W-1:0]   btn,
  output logic [7:0]         byte_out
);
  rd_fmt_e    fmt;
  logic [3:0] lo_nib;
  logic [1:0] hi_pair;

  always_comb begin
    if (phase == PHASE_W'(EXTRA_PHASE))     fmt = FMT_EXTRA;
    else if (phase == PHASE_W'(ONES_PHASE)) fmt = FMT_ONES;
    else                                    fmt = FMT_NORMAL;
  end

  always_comb begin
    if (th) begin
      hi_pair = {btn[B_C], btn[B_B]};
      if (fmt == FMT_EXTRA)
        lo_nib = {btn[B_MODE], btn[B_X], btn[B_Y], btn[B_Z]};
      else
        lo_nib = {btn[B_RIGHT], btn[B_LEFT], btn[B_DOWN], btn[B_UP]};
    end else begin
      hi_pair = {btn[B_START], btn[B_A]};
      case (fmt)
        FMT_EXTRA: lo_nib = 4'h0;
        FMT_ONES:  lo_nib = 4'hF;
        default:   lo_nib = {2'b00, btn[B_DOWN], btn[B_UP]};
      endcase
    end
    byte_out = {1'b0, th, hi_pair, lo_nib};
  end
endmodule

// File: rtl/pad6_port.sv
module pad6_port
  import pad6_pkg::*;
#(
  parameter int PHASE_W        = 3,
  parameter int TIMEOUT_CYCLES = 1500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  input  logic [BTN_W-1:0] buttons,
  output logic             rd_valid,
  output logic [7:0]       rd_data
);
  logic               th_q;
  logic [PHASE_W-1:0] phase_q;
  logic [7:0]         fmt_byte;

  pad6_phase_ctrl #(
    .PHASE_W        (PHASE_W),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .sel_in (wr_data[SEL_BIT]),
    .th     (th_q),
    .phase  (phase_q)
  );

  pad6_read_fmt #(
    .PHASE_W (PHASE_W)
  ) i_fmt (
    .th       (th_q),
    .phase    (phase_q),
    .btn      (buttons),
    .byte_out (fmt_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)
        rd_data <= fmt_byte;
    end
  end
endmodule

// File: rtl/pad6_port_chk.sv
module pad6_port_chk #(
  parameter int PHASE_W        = 3,
  parameter int TIMEOUT_CYCLES = 1500
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [7:0]         wr_data,
  input logic               rd_en,
  input logic               rd_valid,
  input logic [7:0]         rd_data,
  input logic               th,
  input logic [PHASE_W-1:0] phase
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [PHASE_W-1:0] PMAX = {PHASE_W{1'b1}};
  logic [CW-1:0] quiet;

  always_ff @(posedge clk) begin
    if (rst || wr_en) quiet <= '0;
    else if (quiet != CW'(TIMEOUT_CYCLES)) quiet <= quiet + 1'b1;
  end

  p_th_follow_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> th == $past(wr_data[6]));

  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && th && !wr_data[6] && phase != PMAX) |=> phase == $past(phase) + 1'b1);

  p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(th && !wr_data[6])) |=> $stable(phase));

  p_timeout_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (quiet == CW'(TIMEOUT_CYCLES)) |-> phase == '0);

  p_saturate_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && phase == PMAX) |=> phase == PMAX);

  p_rd_latency_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_bit7_zero_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !rd_data[7]);

  p_sel_echo_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_data[6] == $past(th));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind pad6_port pad6_port_chk #(
  .PHASE_W        (PHASE_W),
  .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .th       (th_q),
  .phase    (phase_q)
);

// File: tb/test_pad6_port.sv
module test_pad6_port;
  localparam int PW  = 3;
  localparam int TMO = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_en = 1'b0;
  logic [11:0] buttons = 12'h000;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  // bench model of the port state
  logic       th_m = 1'b1;
  int         ph_m = 0;

  always #2 clk = ~clk;

  pad6_port #(.PHASE_W(PW), .TIMEOUT_CYCLES(TMO)) i_pad6_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .buttons(buttons), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [7:0] model(input logic th, input int ph, input logic [11:0] b);
    if (ph == 3 && !th) return {2'b00, b[7], b[6], 4'h0};
    if (ph == 3 &&  th) return {2'b01, b[5], b[4], b[11], b[10], b[9], b[8]};
    if (ph == 4 && !th) return {2'b00, b[7], b[6], 4'hF};
    if (th)             return {2'b01, b[5], b[4], b[3:0]};
    return {2'b00, b[7], b[6], 2'b00, b[1:0]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (th_m && !d[6] && ph_m != 7) ph_m++;
    th_m = d[6];
  endtask

  task automatic do_read(input string tag);
    exp_t e;
    e.val = model(th_m, ph_m, buttons);
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected result actual=%02h expected=none", rd_data);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, rd_data, e.val);
      end
    end
  end

  task automatic finish_run;
    if (sb_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R10 missing results actual=0 expected=%0d", sb_q.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset rd_valid", {7'd0, rd_valid}, 8'h00);
    check("R1 reset rd_data", rd_data, 8'h00);

    buttons = 12'hA5E;
    do_read("R3 phase0 select high");
    do_write(8'h00);                 // phase 1, low
    do_read("R4 phase1 select low R1");
    do_write(8'h40);
    do_read("R3 phase1 select high");
    buttons = 12'h5A3;
    do_write(8'h00);                 // phase 2
    do_read("R4 phase2 select low");
    do_write(8'h40);
    do_read("R3 phase2 select high");
    do_write(8'h00);                 // phase 3
    do_read("R5 phase3 select low");
    do_write(8'h40);
    do_read("R6 phase3 select high");
    buttons = 12'h9C6;
    do_read("R6 phase3 other buttons");
    do_write(8'h00);                 // phase 4
    do_read("R7 phase4 select low");
    do_write(8'h40);
    do_read("R7 phase4 select high normal");
    do_write(8'h00);                 // phase 5
    do_read("R9 phase5 select low normal");
    for (int i = 0; i < 6; i++) begin
      do_write(8'h40);
      do_write(8'h00);
    end
    do_read("R9 saturated select low normal");
    do_write(8'h40);
    do_read("R9 saturated select high normal");

    // R10 hold: no read, data unchanged
    held = rd_data;
    idle(3);
    check("R10 hold rd_data", rd_data, held);
    check("R10 rd_valid low", {7'd0, rd_valid}, 8'h00);

    // R8 timeout clears phase
    idle(TMO + 10);
    ph_m = 0;
    buttons = 12'h3F3;
    do_write(8'h00);                 // phase 1
    do_read("R8 after timeout phase1 low");

    // R2 redundant writes: low-while-low and high-while-high, other bits set
    do_write(8'hBF);                 // bit6 clear, already low
    do_write(8'hBF);
    do_read("R2 low repeat keeps phase1");
    do_write(8'h40);
    do_write(8'hFF);                 // high again
    do_write(8'h3F);                 // phase 2
    do_write(8'h40);
    do_write(8'h00);                 // phase 3
    do_read("R2 R5 phase3 reached after redundant writes");

    // R8 below timeout keeps phase; beyond it clears
    do_write(8'h40);
    idle(TMO - 12);
    do_write(8'h00);                 // phase 4
    do_read("R8 under limit phase4 kept R7");
    do_write(8'h40);
    idle(TMO + 10);
    ph_m = 0;
    do_write(8'h00);                 // phase 1 after clear
    do_read("R8 over limit phase reset");
    do_write(8'h40);
    do_write(8'h00);
    do_write(8'h40);
    do_write(8'h00);                 // phase 3 again
    do_read("R8 R5 fresh burst reaches phase3");

    idle(4);
    done = 1'b1;
    finish_run();
  end
endmodule